// File: doc/BRIEF.md
# Programmable interrupt trigger detector

This block conditions a bank of interrupt request lines. Each line carries a 2-bit sense code that picks one of four behaviours: active-high level, active-low level, rising edge or falling edge. Every raw input first passes through a two-flop synchronizer. A level-mode line then drives its pending output straight from the synchronized, polarity-corrected input. An edge-mode line sets a sticky pending bit on the chosen transition, and the bit stays set until that line's clear strobe.

The lines fall into two groups, each with its own configuration bank. The private group holds lines 0 to LOCAL_LINES-1. The shared group holds the lines after that, indexed from zero within the group. Each bank packs sixteen 2-bit codes into every 32-bit word. Software changes one line by reading its word, editing the field and writing the word back. The register port is a plain single-cycle port: a write takes effect at the clock edge, and read data is combinational from the current address.

Top module: `tdet_top`

## Requirements
- R1: Sense code values: 0 is active-high level, 1 is active-low level, 2 is rising edge, 3 is falling edge.
- R2: Field layout and bank addresses:
  - Line j of a bank (j counted from 0 within the bank) uses bits [2*(j%16)+1 : 2*(j%16)] of word j/16.
  - Private bank (cfg_bank=0) words sit at byte offsets 0x14, 0x18, and so on.
  - Shared bank (cfg_bank=1) words sit at 0x100, 0x104, and so on.
  - Shared line 32+k is field k of that bank.
- R3: A read returns the word last written at that address. A write to one word leaves every other word unchanged, so a read-modify-write of one field keeps all other fields.
- R4: An address that is not a mapped, 4-byte-aligned word of the selected bank reads as 0. A write to such an address changes no stored field.
- R5: After reset every sense code reads 0 and every pending output is 0 while its raw input is low.
- R6: In level mode, pending equals the raw input (code 0) or its inverse (code 1), delayed by exactly two clock edges through the synchronizer.
- R7: In edge mode, the selected transition of the raw input sets pending three clock edges after the input changes. The opposite transition does not set it. A set bit stays 1 until cleared.
- R8: A clear strobe high at a clock edge resets a latched edge pending bit. If a new selected transition is recognized at that same edge, the set wins and pending stays 1.
- R9: A change of a line's sense code clears that line's latched edge pending bit, with priority over edge detection.
- R10: The clear strobe has no effect on a line in level mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the configuration port |
| cfg_bank | input | 1 | Bank select: 0 private, 1 shared |
| cfg_addr | input | AW | Byte offset within the selected bank |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_bank/cfg_addr (combinational) |
| irq_raw | input | LOCAL_LINES+SHARED_LINES | Asynchronous raw interrupt inputs |
| irq_clr | input | LOCAL_LINES+SHARED_LINES | Per-line clear strobes for latched edge requests |
| irq_pend | output | LOCAL_LINES+SHARED_LINES | Per-line pending requests |

## Verification
The sharpest overlap is a clear strobe arriving at the same edge where a fresh synchronized transition is recognized. The bench first latches a line. It then drops the input, raises it again, and times the strobe to the third edge after the rise, so both actions land together. Pending must stay 1 there, and a lone strobe one test later must drop it. A sense-code write landing while an edge is in flight is the second overlap, and the checker requires the mode-change clear to win.

// File: rtl/tdet_pkg.sv
package tdet_pkg;
  localparam int FIELD_W = 2;
  localparam int FIELDS_PER_WORD = 32 / FIELD_W;

  typedef enum logic [1:0] {
    SENSE_HI   = 2'd0,
    SENSE_LO   = 2'd1,
    SENSE_RISE = 2'd2,
    SENSE_FALL = 2'd3
  } sense_e;

  function automatic int words_for(input int lines);
    return (lines + FIELDS_PER_WORD - 1) / FIELDS_PER_WORD;
  endfunction
endpackage

// File: rtl/tdet_cfg_bank.sv
module tdet_cfg_bank
  import tdet_pkg::*;
#(
  parameter int LINES = 32,
  parameter int BASE  = 'h14,
  parameter int AW    = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic [LINES-1:0][1:0] mode
);
  localparam int NWORDS = words_for(LINES);

  for (genvar i = 0; i < LINES; i++) begin : g_field
    localparam int WORD = i / FIELDS_PER_WORD;
    localparam int POS  = FIELD_W * (i % FIELDS_PER_WORD);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mode[i] <= SENSE_HI;
      else if (wr_en && addr == AW'(BASE + 4 * WORD))
        mode[i] <= wdata[POS +: FIELD_W];
    end
  end

  always_comb begin
    rdata = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (addr == AW'(BASE + 4 * w)) begin
        for (int f = 0; f < FIELDS_PER_WORD; f++) begin
          if (w * FIELDS_PER_WORD + f < LINES)
            rdata[FIELD_W*f +: FIELD_W] = mode[w * FIELDS_PER_WORD + f];
        end
      end
    end
  end
endmodule

// File: rtl/tdet_line.sv
module tdet_line
  import tdet_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       raw,
  input  logic       clr,
  input  logic [1:0] mode,
  output logic       pend
);
  logic sync1, sync2, prev;
  logic [1:0] mode_seen;
  logic latched;
  logic edge_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      prev  <= 1'b0;
    end else begin
      sync1 <= raw;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  always_comb begin
    unique case (sense_e'(mode))
      SENSE_RISE: edge_hit = sync2 & ~prev;
      SENSE_FALL: edge_hit = ~sync2 & prev;
      default:    edge_hit = 1'b0;
    endcase
  end

  // Mode change beats a new edge, a new edge beats a clear strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_seen <= SENSE_HI;
      latched   <= 1'b0;
    end else begin
      mode_seen <= mode;
      if (mode != mode_seen)
        latched <= 1'b0;
      else if (edge_hit)
        latched <= 1'b1;
      else if (clr)
        latched <= 1'b0;
    end
  end

  assign pend = mode[1] ? latched : (sync2 ^ mode[0]);
endmodule

// File: rtl/tdet_top.sv
module tdet_top
  import tdet_pkg::*;
#(
  parameter int LOCAL_LINES  = 32,
  parameter int SHARED_LINES = 32,
  parameter int AW           = 12,
  parameter int LOCAL_BASE   = 'h14,
  parameter int SHARED_BASE  = 'h100,
  localparam int N = LOCAL_LINES + SHARED_LINES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr_en,
  input  logic          cfg_bank,
  input  logic [AW-1:0] cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic [N-1:0]  irq_raw,
  input  logic [N-1:0]  irq_clr,
  output logic [N-1:0]  irq_pend
);
  logic [31:0] local_rdata, shared_rdata;
  logic [LOCAL_LINES-1:0][1:0]  local_mode;
  logic [SHARED_LINES-1:0][1:0] shared_mode;
  logic [N-1:0][1:0] line_mode;

  tdet_cfg_bank #(.LINES(LOCAL_LINES), .BASE(LOCAL_BASE), .AW(AW)) u_local_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (cfg_wr_en && !cfg_bank),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .rdata (local_rdata),
    .mode  (local_mode)
  );

  tdet_cfg_bank #(.LINES(SHARED_LINES), .BASE(SHARED_BASE), .AW(AW)) u_shared_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (cfg_wr_en && cfg_bank),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .rdata (shared_rdata),
    .mode  (shared_mode)
  );

  assign cfg_rdata = cfg_bank ? shared_rdata : local_rdata;
  assign line_mode = {shared_mode, local_mode};

  for (genvar i = 0; i < N; i++) begin : g_line
    tdet_line u_line (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (irq_raw[i]),
      .clr   (irq_clr[i]),
      .mode  (line_mode[i]),
      .pend  (irq_pend[i])
    );
  end
endmodule

// File: rtl/tdet_chk.sv
module tdet_chk #(
  parameter int N = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr_en,
  input logic [N-1:0][1:0] modes,
  input logic [N-1:0]      irq_raw,
  input logic [N-1:0]      irq_clr,
  input logic [N-1:0]      irq_pend
);
  logic [2:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 3'd4) age <= age + 3'd1;
  end
  logic warm;
  assign warm = (age == 3'd4);

  for (genvar i = 0; i < N; i++) begin : g_chk
    a_r6_level_high: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && modes[i] == 2'd0) |-> (irq_pend[i] == $past(irq_raw[i], 2)));

    a_r6_level_low: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && modes[i] == 2'd1) |-> (irq_pend[i] == !$past(irq_raw[i], 2)));

    a_r7_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && modes[i][1] && $stable(modes[i]) && irq_pend[i] && !irq_clr[i] && !cfg_wr_en)
      |=> irq_pend[i]);

    a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && modes[i][1] && $stable(modes[i]) && irq_clr[i] && !cfg_wr_en &&
       ($past(irq_raw[i], 2) == $past(irq_raw[i], 3)))
      |=> !irq_pend[i]);

    a_r9_mode_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && modes[i][1] && !$stable(modes[i]) && !cfg_wr_en) |=> !irq_pend[i]);
  end
endmodule

bind tdet_top tdet_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_wr_en (cfg_wr_en),
  .modes     (line_mode),
  .irq_raw   (irq_raw),
  .irq_clr   (irq_clr),
  .irq_pend  (irq_pend)
);

// File: tb/tdet_top_test.sv
module tdet_top_test;
  localparam int N = 64;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr_en = 1'b0;
  logic          cfg_bank = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   cfg_rdata;
  logic [N-1:0]  irq_raw = '0;
  logic [N-1:0]  irq_clr = '0;
  logic [N-1:0]  irq_pend;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tdet_top uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_bank(cfg_bank),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .irq_raw(irq_raw), .irq_clr(irq_clr), .irq_pend(irq_pend)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic bank, input int addr, input logic [31:0] data);
    @(negedge clk);
    cfg_bank = bank; cfg_addr = AW'(addr); cfg_wdata = data; cfg_wr_en = 1'b1;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic bank, input int addr, output logic [31:0] data);
    cfg_bank = bank; cfg_addr = AW'(addr);
    #1 data = cfg_rdata;
  endtask

  task automatic set_mode(input logic bank, input int addr, input int pos, input logic [1:0] code);
    logic [31:0] w;
    rd(bank, addr, w);
    w[pos +: 2] = code;
    wr(bank, addr, w);
    cyc(2);
  endtask

  task automatic pulse_clr(input int line);
    irq_clr[line] = 1'b1;
    @(negedge clk);
    irq_clr[line] = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] w;
    rd(1'b0, 'h14, w); chk(w, 0, "R5 private word0 reset");
    rd(1'b1, 'h104, w); chk(w, 0, "R5 shared word1 reset");
    chk(irq_pend, 0, "R5 pending after reset");
  endtask

  task automatic t_regs;
    logic [31:0] w;
    wr(1'b0, 'h14, 32'h5A5A_0F0F);
    set_mode(1'b0, 'h14, 10, 2'd3); // line 5 -> falling
    rd(1'b0, 'h14, w); chk(w, 32'h5A5A_0F0F & ~32'hC00 | 32'hC00, "R3 rmw keeps other fields");
    rd(1'b0, 'h18, w); chk(w, 0, "R3 neighbour word untouched");
    wr(1'b1, 'h104, 32'h0000_0030); // shared line 32+18=50, field 2
    rd(1'b1, 'h104, w); chk(w, 32'h30, "R2 shared word readback");
    rd(1'b1, 'h100, w); chk(w, 0, "R2 shared word0 untouched");
    wr(1'b0, 'h14, 0);
    wr(1'b1, 'h104, 0);
    cyc(3);
  endtask

  task automatic t_unmapped;
    logic [31:0] w;
    wr(1'b0, 'h10, 32'hFFFF_FFFF);
    wr(1'b0, 'h16, 32'hFFFF_FFFF);
    wr(1'b1, 'h108, 32'hFFFF_FFFF);
    rd(1'b0, 'h10, w); chk(w, 0, "R4 unmapped read zero");
    rd(1'b0, 'h14, w); chk(w, 0, "R4 unaligned write ignored");
    rd(1'b1, 'h100, w); chk(w, 0, "R4 shared out-of-range write ignored");
    rd(1'b1, 'h104, w); chk(w, 0, "R4 shared word1 unchanged");
  endtask

  task automatic t_level;
    // line 20: private word 0x18 bits 9:8; code 0 high level
    irq_raw[20] = 1'b1;
    cyc(1); chk(irq_pend[20], 0, "R6 level not yet through sync");
    cyc(1); chk(irq_pend[20], 1, "R6 level high after two edges");
    irq_raw[20] = 1'b0;
    cyc(2); chk(irq_pend[20], 0, "R6 level high follows drop");
    set_mode(1'b0, 'h18, 8, 2'd1);
    chk(irq_pend[20], 1, "R1 R6 active-low with input low");
    pulse_clr(20);
    chk(irq_pend[20], 1, "R10 clear ignored in level mode");
    irq_raw[20] = 1'b1;
    cyc(2); chk(irq_pend[20], 0, "R6 active-low with input high");
    irq_raw[20] = 1'b0;
    set_mode(1'b0, 'h18, 8, 2'd0);
  endtask

  task automatic t_rise_and_collide;
    set_mode(1'b0, 'h14, 10, 2'd2); // line 5 rising
    irq_raw[5] = 1'b1;
    cyc(2); chk(irq_pend[5], 0, "R7 rising not before third edge");
    cyc(1); chk(irq_pend[5], 1, "R7 rising sets pending");
    irq_raw[5] = 1'b0;
    cyc(5); chk(irq_pend[5], 1, "R7 sticky across falling input");
    irq_raw[5] = 1'b1;
    cyc(2);
    irq_clr[5] = 1'b1; // lands on the edge that recognizes the rise
    cyc(1);
    irq_clr[5] = 1'b0;
    chk(irq_pend[5], 1, "R8 set wins over same-cycle clear");
    pulse_clr(5);
    chk(irq_pend[5], 0, "R8 plain clear drops pending");
    irq_raw[5] = 1'b0;
    cyc(4); chk(irq_pend[5], 0, "R7 falling ignored in rising mode");
  endtask

  task automatic t_fall_shared;
    irq_raw[50] = 1'b1;
    cyc(3);
    set_mode(1'b1, 'h104, 4, 2'd3); // shared line 50 falling
    chk(irq_pend[50], 0, "R1 falling mode idle while high");
    irq_raw[50] = 1'b0;
    cyc(3); chk(irq_pend[50], 1, "R7 falling edge sets pending");
    pulse_clr(50);
    chk(irq_pend[50], 0, "R8 clear on shared line");
  endtask

  task automatic t_mode_change;
    set_mode(1'b1, 'h100, 10, 2'd2); // shared line 37 rising
    irq_raw[37] = 1'b1;
    cyc(3); chk(irq_pend[37], 1, "R7 shared rising sets");
    set_mode(1'b1, 'h100, 10, 2'd3);
    chk(irq_pend[37], 0, "R9 mode change clears latch");
    cyc(3); chk(irq_pend[37], 0, "R9 no spurious set after change");
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_regs();
    t_unmapped();
    t_level();
    t_rise_and_collide();
    t_fall_shared();
    t_mode_change();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int k = 0; k < 100000; k++) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule